// File: doc/BRIEF.md
# Single-Context Interrupt Claim/Complete Controller

This block gathers a set of level-sensitive interrupt lines for one hart context. Each line passes through a small gateway that latches a pending flag. Each source has a programmable priority and an enable bit. An arbiter selects the best source that is pending and enabled, and an interrupt-request line tells the hart that such a source is waiting.

Software uses one claim/complete word. A read of that word claims the winning source: it returns the source number, clears the pending flag and marks the source as in service. In service, the gateway accepts no new request from that line. Writing the source number back to the same word ends the service. That write is accepted only while the source's enable bit is set.

A configuration input selects the auto-mask variant. In that variant a claim also clears the source's enable bit. A completion written before software sets the enable bit again is then dropped, and the source stays in service.

Top module: `irq_claim_ctrl`

## Requirements
- R1: A read of word address 0 returns, one cycle later on `reg_rdata`, the number of the pending, enabled source with the highest non-zero priority, or 0 when no such source exists.
- R2: Among equal priorities the lower source number wins, and a source with priority 0 is never returned by a claim.
- R3: A claim that returns a non-zero number clears that source's pending flag and marks it in service, in the same access.
- R4: A write of source number k (1..NUM_SRC) to word address 0 while source k is enabled ends its service. If its line is still high, the source becomes pending again one cycle later.
- R5: A completion write is ignored when the source is disabled, or when the written value is 0 or larger than NUM_SRC (no truncation of the value). An ignored completion leaves all state unchanged.
- R6: While a source is in service, its line cannot set its pending flag, and the source is never pending and in service at once.
- R7: With `automask_en` low, a claim leaves every enable bit unchanged.
- R8: With `automask_en` high, a claim clears the claimed source's enable bit. The source then stays in service until software sets the enable bit again and writes the completion.
- R9: `irq` is high exactly when some source is pending, enabled and has non-zero priority.
- R10: Reset (synchronous, `rst_n` low) clears all pending, in-service and enable bits and all priorities. `reg_rdata` reads 0 after reset.
- R11: The register map has four parts. Word 1 holds the enables, with bit k for source k and bit 0 reading 0. Word 2 is the read-only pending map in the same bit layout. Word 32+k holds source k's priority in its low PRIO_W bits. Reads of any other address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| automask_en | input | 1 | 1 selects mask-on-claim behaviour |
| src_lvl | input | NUM_SRC | Level inputs; bit k-1 is source k |
| reg_req | input | 1 | Register access strobe (one access per cycle) |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 6 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| irq | output | 1 | Interrupt request to the hart |

## Verification
The bench builds the block with NUM_SRC = 5 and PRIO_W = 2. With only four priority levels, ties and priority-0 sources are easy to set up. With five sources the top legal number and the out-of-range values 6, 7 and 10 can all be written as completions. The value 10 only passes as source 2 if its upper bits are dropped, so it catches a truncated completion number. The sequence runs the claim order, gateway blocking, dropped completions for disabled sources, and the stuck-then-recovered path in auto-mask mode.

// File: rtl/irq_cc_pkg.sv
// Package: shared address map and bus widths of the claim/complete controller.
// Assumes word addressing with one access per cycle.
package irq_cc_pkg;
    localparam int ADDR_W         = 6;
    localparam int DATA_W         = 32;
    localparam int ADDR_CLAIM     = 0;
    localparam int ADDR_ENABLE    = 1;
    localparam int ADDR_PENDING   = 2;
    localparam int ADDR_PRIO_BASE = 32;
endpackage

// File: rtl/irq_cc_gateway.sv
// Module: per-source gateway. Latches a pending flag from a level line and
// tracks the in-service state. Assumes claim_hit is only asserted while
// pending is set, and that complete_hit is already qualified by the enable bit.
module irq_cc_gateway (
    input  logic clk,
    input  logic rst_n,
    input  logic src,
    input  logic claim_hit,
    input  logic complete_hit,
    output logic pending,
    output logic claimed
);
    // Pending: set by the line only when idle, cleared by a claim.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending <= 1'b0;
        else if (claim_hit)
            pending <= 1'b0;
        else if (src && !pending && !claimed)
            pending <= 1'b1;
    end

    // In service: set by a claim, cleared by an accepted completion.
    always_ff @(posedge clk) begin
        if (!rst_n)
            claimed <= 1'b0;
        else if (claim_hit)
            claimed <= 1'b1;
        else if (complete_hit)
            claimed <= 1'b0;
    end
endmodule

// File: rtl/irq_cc_arbiter.sv
// Module: picks the eligible source with the highest priority; ties go to
// the lower number. Priority 0 never wins. Number 0 means none.
module irq_cc_arbiter #(
    parameter int NUM_SRC = 8,
    parameter int PRIO_W  = 3,
    localparam int ID_W   = $clog2(NUM_SRC + 1)
) (
    input  logic [NUM_SRC:1]             elig,
    input  logic [NUM_SRC:1][PRIO_W-1:0] prio,
    output logic [ID_W-1:0]              best_id
);
    logic [PRIO_W-1:0] best_p;

    // Ascending scan with strict compare keeps the lowest number on ties.
    always_comb begin
        best_id = '0;
        best_p  = '0;
        for (int i = 1; i <= NUM_SRC; i++) begin
            if (elig[i] && (prio[i] > best_p)) begin
                best_p  = prio[i];
                best_id = ID_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_claim_ctrl.sv
// Module: single-context interrupt controller with a claim/complete word.
// Assumes NUM_SRC + 1 <= 32 and NUM_SRC <= 31 (priority window 32..63).
module irq_claim_ctrl
    import irq_cc_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int PRIO_W  = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                automask_en,
    input  logic [NUM_SRC-1:0]  src_lvl,
    input  logic                reg_req,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic                irq
);
    localparam int ID_W = $clog2(NUM_SRC + 1);

    logic [NUM_SRC:1]             pend_q, claim_q, en_q;
    logic [NUM_SRC:1][PRIO_W-1:0] prio_q;
    logic [NUM_SRC:1]             claim_hit, cmpl_hit;
    logic [ID_W-1:0]              best_id;
    logic                         rd_claim, wr_cmpl, wr_en, cmpl_in_range;
    logic [PRIO_W-1:0]            prio_rd;
    logic                         prio_rd_hit;

    // Decode of the access strobe.
    assign rd_claim      = reg_req && !reg_we && (reg_addr == ADDR_W'(ADDR_CLAIM));
    assign wr_cmpl       = reg_req &&  reg_we && (reg_addr == ADDR_W'(ADDR_CLAIM));
    assign wr_en         = reg_req &&  reg_we && (reg_addr == ADDR_W'(ADDR_ENABLE));
    assign cmpl_in_range = (reg_wdata != '0) && (reg_wdata <= DATA_W'(NUM_SRC));

    // One gateway per source, with its claim and completion strobes.
    for (genvar g = 1; g <= NUM_SRC; g++) begin : g_src
        assign claim_hit[g] = rd_claim && (best_id == ID_W'(g));
        assign cmpl_hit[g]  = wr_cmpl && cmpl_in_range &&
                              (reg_wdata[ID_W-1:0] == ID_W'(g)) && en_q[g];

        irq_cc_gateway u_gw (
            .clk          (clk),
            .rst_n        (rst_n),
            .src          (src_lvl[g-1]),
            .claim_hit    (claim_hit[g]),
            .complete_hit (cmpl_hit[g]),
            .pending      (pend_q[g]),
            .claimed      (claim_q[g])
        );

        // Priority register of this source.
        always_ff @(posedge clk) begin
            if (!rst_n)
                prio_q[g] <= '0;
            else if (reg_req && reg_we && (reg_addr == ADDR_W'(ADDR_PRIO_BASE + g)))
                prio_q[g] <= reg_wdata[PRIO_W-1:0];
        end

        // Enable bit: software write, or cleared by a claim in auto-mask mode.
        always_ff @(posedge clk) begin
            if (!rst_n)
                en_q[g] <= 1'b0;
            else if (wr_en)
                en_q[g] <= reg_wdata[g];
            else if (claim_hit[g] && automask_en)
                en_q[g] <= 1'b0;
        end
    end

    irq_cc_arbiter #(
        .NUM_SRC (NUM_SRC),
        .PRIO_W  (PRIO_W)
    ) u_arb (
        .elig    (pend_q & en_q),
        .prio    (prio_q),
        .best_id (best_id)
    );

    // The request line follows the arbiter result.
    assign irq = (best_id != '0);

    // Priority read mux over the priority window.
    always_comb begin
        prio_rd     = '0;
        prio_rd_hit = 1'b0;
        for (int i = 1; i <= NUM_SRC; i++) begin
            if (reg_addr == ADDR_W'(ADDR_PRIO_BASE + i)) begin
                prio_rd     = prio_q[i];
                prio_rd_hit = 1'b1;
            end
        end
    end

    // Registered read data; a claim returns the winner selected at this edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            reg_rdata <= '0;
        else if (reg_req && !reg_we) begin
            if (reg_addr == ADDR_W'(ADDR_CLAIM))
                reg_rdata <= DATA_W'(best_id);
            else if (reg_addr == ADDR_W'(ADDR_ENABLE))
                reg_rdata <= DATA_W'({en_q, 1'b0});
            else if (reg_addr == ADDR_W'(ADDR_PENDING))
                reg_rdata <= DATA_W'({pend_q, 1'b0});
            else if (prio_rd_hit)
                reg_rdata <= DATA_W'(prio_rd);
            else
                reg_rdata <= '0;
        end
    end
endmodule

// File: rtl/irq_cc_chk.sv
// Module: property checker for irq_claim_ctrl, attached through bind.
module irq_cc_chk
    import irq_cc_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int PRIO_W  = 3,
    localparam int ID_W   = $clog2(NUM_SRC + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              automask_en,
    input logic              reg_req,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              irq,
    input logic [NUM_SRC:1]  pend_q,
    input logic [NUM_SRC:1]  claim_q,
    input logic [NUM_SRC:1]  en_q,
    input logic [ID_W-1:0]   best_id
);
    logic rd_c, wr_c, id_enabled;

    assign rd_c = reg_req && !reg_we && (reg_addr == ADDR_W'(ADDR_CLAIM));
    assign wr_c = reg_req &&  reg_we && (reg_addr == ADDR_W'(ADDR_CLAIM));

    // Whether the written completion number names an enabled source.
    always_comb begin
        id_enabled = 1'b0;
        for (int i = 1; i <= NUM_SRC; i++)
            if (reg_wdata == DATA_W'(i)) id_enabled = en_q[i];
    end

    a_r1_empty_claim: assert property (@(posedge clk) disable iff (!rst_n)
        rd_c && ((pend_q & en_q) == '0) |=> reg_rdata == '0);

    a_r3_claim_marks: assert property (@(posedge clk) disable iff (!rst_n)
        rd_c && (best_id != '0) |=> $countones(claim_q) == $past($countones(claim_q)) + 1);

    a_r5_drop_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        wr_c && !id_enabled |=> $stable(claim_q));

    a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q & claim_q) == '0);

    a_r7_std_keeps_en: assert property (@(posedge clk) disable iff (!rst_n)
        rd_c && !automask_en |=> $stable(en_q));

    a_r8_mask_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rd_c && automask_en && (best_id != '0) |=> $countones(en_q) == $past($countones(en_q)) - 1);

    a_r9_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (pend_q & en_q) != '0);
endmodule

bind irq_claim_ctrl irq_cc_chk #(
    .NUM_SRC (NUM_SRC),
    .PRIO_W  (PRIO_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .automask_en (automask_en),
    .reg_req     (reg_req),
    .reg_we      (reg_we),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .irq         (irq),
    .pend_q      (pend_q),
    .claim_q     (claim_q),
    .en_q        (en_q),
    .best_id     (best_id)
);

// File: tb/irq_claim_ctrl_tb.sv
module irq_claim_ctrl_tb;
    localparam int N  = 5;
    localparam int PW = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         automask_en = 1'b0;
    logic [N-1:0] src_lvl = '0;
    logic         reg_req = 1'b0;
    logic         reg_we = 1'b0;
    logic [5:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         irq;

    int checks = 0;
    int errors = 0;
    logic rd_seen = 1'b0;
    logic done = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    irq_claim_ctrl #(.NUM_SRC(N), .PRIO_W(PW)) u_dut (
        .clk(clk), .rst_n(rst_n), .automask_en(automask_en), .src_lvl(src_lvl),
        .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Monitor: compares each read result with the scoreboard head.
    always @(posedge clk) rd_seen <= reg_req && !reg_we;
    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0)
            chk(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
    end

    task automatic rd(logic [5:0] a, logic [31:0] exp, string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        reg_req = 1'b1; reg_we = 1'b0; reg_addr = a;
        @(posedge clk); @(negedge clk);
        reg_req = 1'b0;
    endtask

    task automatic wr(logic [5:0] a, logic [31:0] d);
        reg_req = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); @(negedge clk);
        reg_req = 1'b0; reg_we = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) begin @(posedge clk); @(negedge clk); end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 irq after reset", 32'(irq), 0);
        rd(6'd0, 0, "R10 claim empty after reset");
        rd(6'd1, 0, "R10 enables cleared");
        rd(6'd2, 0, "R10 pending cleared");
        // priorities: 1->1, 2->3, 3->3, 4->0, 5->2
        wr(6'd33, 1); wr(6'd34, 3); wr(6'd35, 3); wr(6'd36, 0); wr(6'd37, 2);
        wr(6'd1, 32'h3E);
        chk("R9 irq low with no lines", 32'(irq), 0);
        src_lvl = 5'b11111;
        idle(1);
        chk("R9 irq with eligible source", 32'(irq), 1);
        rd(6'd2, 32'h3E, "R11 pending map");
        rd(6'd0, 2, "R2 tie goes to lower number");
        rd(6'd2, 32'h3A, "R3 R6 claim clears pending, held line blocked");
        rd(6'd0, 3, "R1 next highest");
        rd(6'd0, 5, "R1 priority 2");
        rd(6'd0, 1, "R1 priority 1");
        rd(6'd0, 0, "R2 priority 0 never claimed");
        chk("R9 irq low with only priority-0 pending", 32'(irq), 0);
        rd(6'd1, 32'h3E, "R7 standard mode keeps enables");
        wr(6'd0, 7); wr(6'd0, 0); wr(6'd0, 32'h0A);
        idle(1);
        rd(6'd2, 32'h10, "R5 out-of-range completions ignored");
        wr(6'd0, 2);
        idle(1);
        rd(6'd2, 32'h14, "R4 completion re-pends held line");
        wr(6'd1, 32'h36);
        wr(6'd0, 3);
        idle(1);
        rd(6'd2, 32'h14, "R5 completion of disabled source dropped");
        wr(6'd1, 32'h3E);
        wr(6'd0, 3);
        idle(1);
        rd(6'd2, 32'h1C, "R4 completion after re-enable");
        src_lvl = '0;
        wr(6'd0, 1); wr(6'd0, 5);
        idle(1);
        rd(6'd2, 32'h1C, "R4 released low lines stay idle");
        chk("R9 irq with pending sources", 32'(irq), 1);
        // auto-mask mode
        automask_en = 1'b1;
        rd(6'd0, 2, "R8 claim in auto-mask mode");
        rd(6'd1, 32'h3A, "R8 claim cleared enable");
        wr(6'd0, 2);
        src_lvl = 5'b00010;
        idle(2);
        rd(6'd2, 32'h18, "R8 masked completion dropped, source stuck");
        wr(6'd1, 32'h3E);
        wr(6'd0, 2);
        idle(1);
        rd(6'd2, 32'h1C, "R8 re-enable then complete releases");
        rd(6'd0, 2, "R8 second claim");
        rd(6'd1, 32'h3A, "R8 enable cleared again");
        automask_en = 1'b0;
        rd(6'd0, 3, "R7 standard claim");
        rd(6'd1, 32'h3A, "R7 enables untouched");
        rd(6'd33, 1, "R11 priority readback");
        rd(6'd36, 0, "R11 priority zero readback");
        rd(6'd20, 0, "R11 unmapped address");
        src_lvl = '0;
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 irq after second reset", 32'(irq), 0);
        rd(6'd2, 0, "R10 pending cleared again");
        rd(6'd1, 0, "R10 enables cleared again");
        rd(6'd35, 0, "R10 priority cleared");
        rd(6'd0, 0, "R10 claim empty");
        idle(1);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule